// File: doc/BRIEF.md
# Packet Cipher Task and Event Controller

This block is the control shell around a packet encryption engine. Software reaches it through a simple 32-bit register bus. Through that bus it writes task registers that start a keystream job or an encrypt/decrypt job, and it programs the configuration that those jobs use. The cipher datapath is outside this block. The block reaches that datapath through a start/done handshake: a one-cycle `eng_start` with an operation code, then a later `eng_done`, and on decryption a `eng_mic_ok` verdict. The DMA pointers, the maximum packet size, the rate override value and the header mask are storage registers only. The block keeps them for the engine and does not interpret them.

Each completed job sets a sticky event flag. The interrupt line is a level signal formed from the flags and an enable mask. A shortcut bit chains a finished keystream job straight into a crypt job. In decrypt mode a crypt job first waits for the radio's end-of-packet strobe. If that packet carried a CRC error, the integrity check is skipped and reported as failed. The controller also sits on a channel-based event fabric. Each task can subscribe to one fabric channel, and each event can publish a one-cycle pulse onto one channel.

Top module: `pkt_cipher_ctl`

## Requirements
- R1: After reset the mode register reads 0x00000001 (decrypt) and the header mask register (0x520) reads 0x000000E3. Every other register reads 0, and `irq` and `eng_start` are low. The mode register keeps only bit 0 (direction), bits 17:16 (rate) and bit 24 (extended length). The header mask keeps 8 bits. The pointer registers at 0x508 to 0x514 keep all 32 bits.
- R2: The keystream task (0x000) and the crypt task (0x004) are ignored unless the 2-bit enable register (0x500) holds 2. When they are ignored, no `eng_start` is issued and no event is raised.
- R3: A keystream task accepted at a clock edge drives `eng_start` high with `eng_op`=0 for exactly the next cycle. The `eng_done` that ends that job sets the keystream event flag (0x100, bit 0).
- R4: Event flags (0x100 keystream, 0x104 crypt, 0x108 error) are sticky. Writing 0 to bit 0 clears a flag and writing 1 sets it. A flag raised by hardware in the same cycle as a software write takes precedence over the write.
- R5: Writing 1 to a bit of 0x304 sets that interrupt enable bit, and writing 1 to a bit of 0x308 clears it. Bit 0 belongs to the keystream event, bit 1 to the crypt event and bit 2 to the error event. Both addresses read back the 3-bit enable mask.
- R6: `irq` is high exactly when some event flag and its enable bit are both set. It follows every change of a flag or of an enable bit from the cycle after that change.
- R7: When bit 0 of the shortcut register (0x200) is set, the completion of a keystream job starts a crypt job in the same edge that raises the keystream event.
- R8: In encrypt mode (mode bit 0 = 0), a crypt task starts the engine at once with `eng_op`=1. The matching `eng_done` raises the crypt event and leaves the integrity status unchanged.
- R9: In decrypt mode, a crypt task does not start the engine until `rx_end` arrives. After `eng_done`, the integrity status register (0x400, bit 0) holds `eng_mic_ok`, and the crypt event is raised.
- R10: If the awaited `rx_end` arrives with `rx_crc_err` high, no engine job is started. In that case the status reads 0 and the crypt event is raised on the same edge.
- R11: The stop task (0x008) returns the controller to idle. A later `rx_end` or `eng_done` then causes no job and no event.
- R12: A subscribe register sits 0x80 above each task register. Bit 31 enables it and bits 7:0 select a fabric channel. An enabled subscription fires its task on a one-cycle pulse of the selected `chan_in` line, exactly as a register write of 1 would. A disabled subscription, or a pulse on any other line, has no effect.
- R13: A publish register sits 0x80 above each event register, with the same layout as a subscribe register. When an event fires and its publish register is enabled, `chan_out` carries a one-cycle pulse on the selected line. That pulse appears in the same cycle in which the flag first reads 1.
- R14: Task registers always read 0. The rate-override task (0x00C) has no effect on the engine handshake or on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |
| chan_in | input | NCH | Event fabric channel pulses in |
| chan_out | output | NCH | Event fabric channel pulses out |
| eng_start | output | 1 | One-cycle job start to the cipher engine |
| eng_op | output | 1 | Job kind: 0 keystream, 1 crypt |
| eng_decrypt | output | 1 | Current direction from mode bit 0 |
| eng_done | input | 1 | Engine job completion pulse |
| eng_mic_ok | input | 1 | Integrity check verdict, valid with `eng_done` |
| rx_end | input | 1 | End-of-packet strobe from the radio |
| rx_crc_err | input | 1 | CRC error flag, valid with `rx_end` |

## Verification
Every result is due a fixed number of cycles after its stimulus. A task write or a fabric pulse sampled at edge N shows `eng_start` in the cycle after N, and the bench samples it at the next falling edge. An `eng_done`, an `rx_end` with a CRC error, or a shortcut completion sampled at edge N sets the event flag, the status bit and the `chan_out` pulse together after N, and the level interrupt follows from those registers in that same cycle. The bench drives every strobe for exactly one cycle between falling edges and reads the combinational read port a little after a falling edge. Each result is therefore checked in the first cycle it is due, and pulse widths are checked one cycle later.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int NTASK  = 4;   // keystream, crypt, stop, rate override
    localparam int NEV    = 3;   // keystream done, crypt done, error
    localparam int NPTR   = 4;
    localparam int CIDX_W = 8;

    localparam logic [ADDR_W-1:0] A_SUB_BASE = 12'h080;
    localparam logic [ADDR_W-1:0] A_EV_BASE  = 12'h100;
    localparam logic [ADDR_W-1:0] A_PUB_BASE = 12'h180;
    localparam logic [ADDR_W-1:0] A_SHORT    = 12'h200;
    localparam logic [ADDR_W-1:0] A_IEN_SET  = 12'h304;
    localparam logic [ADDR_W-1:0] A_IEN_CLR  = 12'h308;
    localparam logic [ADDR_W-1:0] A_STATUS   = 12'h400;
    localparam logic [ADDR_W-1:0] A_ENABLE   = 12'h500;
    localparam logic [ADDR_W-1:0] A_MODE     = 12'h504;
    localparam logic [ADDR_W-1:0] A_PTR_BASE = 12'h508;
    localparam logic [ADDR_W-1:0] A_MAXSZ    = 12'h518;
    localparam logic [ADDR_W-1:0] A_RATE     = 12'h51C;
    localparam logic [ADDR_W-1:0] A_HMASK    = 12'h520;

    localparam logic [1:0] EN_ON = 2'd2;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_KS, SQ_ENC, SQ_RXW, SQ_DEC
    } sq_state_e;

    typedef struct packed {
        logic              en;
        logic [CIDX_W-1:0] idx;
    } chan_cfg_t;
endpackage

// File: rtl/pcc_sub_match.sv
module pcc_sub_match
    import pcc_pkg::*;
#(
    parameter int NCH = 16
) (
    input  chan_cfg_t        cfg,
    input  logic [NCH-1:0]   lines,
    output logic             hit
);
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (cfg.en && cfg.idx == CIDX_W'(i) && lines[i]) hit = 1'b1;
        end
    end
endmodule

// File: rtl/pcc_pub_drive.sv
module pcc_pub_drive
    import pcc_pkg::*;
#(
    parameter int NCH = 16
) (
    input  chan_cfg_t        cfg,
    input  logic             fire,
    output logic [NCH-1:0]   lines
);
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            lines[i] = fire && cfg.en && (cfg.idx == CIDX_W'(i));
        end
    end
endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
    import pcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go_ks,
    input  logic      go_cr,
    input  logic      go_stop,
    input  logic      enabled,
    input  logic      short_en,
    input  logic      dir_dec,
    input  logic      eng_done,
    input  logic      eng_mic_ok,
    input  logic      rx_end,
    input  logic      rx_crc_err,
    output logic      eng_start,
    output logic      eng_op,
    output logic      fire_ks,
    output logic      fire_cr,
    output logic      mic_we,
    output logic      mic_val,
    output sq_state_e state
);
    typedef struct packed {
        sq_state_e st;
        logic      start;
        logic      op;
    } seq_t;

    seq_t s_q, s_d;
    logic crc_skip, take_ks, take_cr;

    always_comb begin
        crc_skip = (s_q.st == SQ_RXW) && rx_end && rx_crc_err;
        fire_ks  = (s_q.st == SQ_KS) && eng_done;
        fire_cr  = ((s_q.st == SQ_ENC || s_q.st == SQ_DEC) && eng_done) || crc_skip;
        mic_we   = ((s_q.st == SQ_DEC) && eng_done) || crc_skip;
        mic_val  = (s_q.st == SQ_DEC) && eng_mic_ok;
        take_ks  = enabled && go_ks;
        take_cr  = enabled && (go_cr || (fire_ks && short_en));

        s_d       = s_q;
        s_d.start = 1'b0;
        if (fire_ks || fire_cr) s_d.st = SQ_IDLE;
        if (s_q.st == SQ_RXW && rx_end && !rx_crc_err) begin
            s_d.st    = SQ_DEC;
            s_d.start = 1'b1;
            s_d.op    = 1'b1;
        end
        if (take_ks) begin
            s_d.st    = SQ_KS;
            s_d.start = 1'b1;
            s_d.op    = 1'b0;
        end
        if (take_cr) begin
            s_d.st    = dir_dec ? SQ_RXW : SQ_ENC;
            s_d.start = !dir_dec;
            s_d.op    = 1'b1;
        end
        if (go_stop) begin
            s_d.st    = SQ_IDLE;
            s_d.start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, start: 1'b0, op: 1'b0};
        else        s_q <= s_d;
    end

    assign eng_start = s_q.start;
    assign eng_op    = s_q.op;
    assign state     = s_q.st;
endmodule

// File: rtl/pkt_cipher_ctl.sv
module pkt_cipher_ctl
    import pcc_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic [NCH-1:0]    chan_in,
    output logic [NCH-1:0]    chan_out,
    output logic              eng_start,
    output logic              eng_op,
    output logic              eng_decrypt,
    input  logic              eng_done,
    input  logic              eng_mic_ok,
    input  logic              rx_end,
    input  logic              rx_crc_err
);
    typedef struct packed {
        logic [NEV-1:0]             ev;
        logic                       sh;
        logic [NEV-1:0]             ien;
        logic                       mic;
        logic [1:0]                 en;
        logic                       m_dir;
        logic                       m_len;
        logic [1:0]                 m_rate;
        logic [NPTR-1:0][DATA_W-1:0] ptr;
        logic [7:0]                 maxsz;
        logic [1:0]                 rovr;
        logic [7:0]                 hmask;
        chan_cfg_t [NTASK-1:0]      sub;
        chan_cfg_t [NEV-1:0]        pub;
        logic [NCH-1:0]             cout;
    } regs_t;

    regs_t r_q, r_d;
    logic [NTASK-1:0]          sub_hit, trig;
    logic [NEV-1:0]            ev_fire;
    logic [NEV-1:0][NCH-1:0]   pub_lines;
    logic fire_ks, fire_cr, mic_we, mic_val;
    sq_state_e seq_st;

    // subscription match per task, publish drive per event
    for (genvar t = 0; t < NTASK; t++) begin : g_sub
        pcc_sub_match #(.NCH(NCH)) u_sub (
            .cfg(r_q.sub[t]), .lines(chan_in), .hit(sub_hit[t]));
        assign trig[t] = (bus_wr && bus_addr == ADDR_W'(t * 4) && bus_wdata[0]) || sub_hit[t];
    end

    assign ev_fire = {1'b0, fire_cr, fire_ks};

    for (genvar e = 0; e < NEV; e++) begin : g_pub
        pcc_pub_drive #(.NCH(NCH)) u_pub (
            .cfg(r_q.pub[e]), .fire(ev_fire[e]), .lines(pub_lines[e]));
    end

    pcc_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .go_ks(trig[0]), .go_cr(trig[1]), .go_stop(trig[2]),
        .enabled(r_q.en == EN_ON), .short_en(r_q.sh), .dir_dec(r_q.m_dir),
        .eng_done(eng_done), .eng_mic_ok(eng_mic_ok),
        .rx_end(rx_end), .rx_crc_err(rx_crc_err),
        .eng_start(eng_start), .eng_op(eng_op),
        .fire_ks(fire_ks), .fire_cr(fire_cr),
        .mic_we(mic_we), .mic_val(mic_val), .state(seq_st));

    // next-state of the register file
    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            for (int t = 0; t < NTASK; t++)
                if (bus_addr == A_SUB_BASE + ADDR_W'(t * 4))
                    r_d.sub[t] = '{en: bus_wdata[31], idx: bus_wdata[CIDX_W-1:0]};
            for (int e = 0; e < NEV; e++) begin
                if (bus_addr == A_EV_BASE + ADDR_W'(e * 4)) r_d.ev[e] = bus_wdata[0];
                if (bus_addr == A_PUB_BASE + ADDR_W'(e * 4))
                    r_d.pub[e] = '{en: bus_wdata[31], idx: bus_wdata[CIDX_W-1:0]};
            end
            for (int p = 0; p < NPTR; p++)
                if (bus_addr == A_PTR_BASE + ADDR_W'(p * 4)) r_d.ptr[p] = bus_wdata;
            if (bus_addr == A_SHORT)   r_d.sh  = bus_wdata[0];
            if (bus_addr == A_IEN_SET) r_d.ien = r_q.ien | bus_wdata[NEV-1:0];
            if (bus_addr == A_IEN_CLR) r_d.ien = r_q.ien & ~bus_wdata[NEV-1:0];
            if (bus_addr == A_ENABLE)  r_d.en  = bus_wdata[1:0];
            if (bus_addr == A_MODE) begin
                r_d.m_dir  = bus_wdata[0];
                r_d.m_rate = bus_wdata[17:16];
                r_d.m_len  = bus_wdata[24];
            end
            if (bus_addr == A_MAXSZ) r_d.maxsz = bus_wdata[7:0];
            if (bus_addr == A_RATE)  r_d.rovr  = bus_wdata[1:0];
            if (bus_addr == A_HMASK) r_d.hmask = bus_wdata[7:0];
        end
        // hardware-raised events win over a simultaneous software write
        r_d.ev = r_d.ev | ev_fire;
        if (mic_we) r_d.mic = mic_val;
        r_d.cout = '0;
        for (int e = 0; e < NEV; e++) r_d.cout = r_d.cout | pub_lines[e];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.m_dir <= 1'b1;
            r_q.hmask <= 8'hE3;
        end else begin
            r_q <= r_d;
        end
    end

    // read port
    always_comb begin
        bus_rdata = '0;
        for (int t = 0; t < NTASK; t++)
            if (bus_addr == A_SUB_BASE + ADDR_W'(t * 4))
                bus_rdata = {r_q.sub[t].en, {(DATA_W-1-CIDX_W){1'b0}}, r_q.sub[t].idx};
        for (int e = 0; e < NEV; e++) begin
            if (bus_addr == A_EV_BASE + ADDR_W'(e * 4)) bus_rdata = DATA_W'(r_q.ev[e]);
            if (bus_addr == A_PUB_BASE + ADDR_W'(e * 4))
                bus_rdata = {r_q.pub[e].en, {(DATA_W-1-CIDX_W){1'b0}}, r_q.pub[e].idx};
        end
        for (int p = 0; p < NPTR; p++)
            if (bus_addr == A_PTR_BASE + ADDR_W'(p * 4)) bus_rdata = r_q.ptr[p];
        if (bus_addr == A_SHORT)  bus_rdata = DATA_W'(r_q.sh);
        if (bus_addr == A_IEN_SET || bus_addr == A_IEN_CLR) bus_rdata = DATA_W'(r_q.ien);
        if (bus_addr == A_STATUS) bus_rdata = DATA_W'(r_q.mic);
        if (bus_addr == A_ENABLE) bus_rdata = DATA_W'(r_q.en);
        if (bus_addr == A_MODE)
            bus_rdata = {7'd0, r_q.m_len, 6'd0, r_q.m_rate, 15'd0, r_q.m_dir};
        if (bus_addr == A_MAXSZ)  bus_rdata = DATA_W'(r_q.maxsz);
        if (bus_addr == A_RATE)   bus_rdata = DATA_W'(r_q.rovr);
        if (bus_addr == A_HMASK)  bus_rdata = DATA_W'(r_q.hmask);
    end

    assign irq         = |(r_q.ev & r_q.ien);
    assign chan_out    = r_q.cout;
    assign eng_decrypt = r_q.m_dir;

    // state views for the bound checker
    logic [NEV-1:0] ev_q, ien_q;
    logic [1:0]     en_q;
    logic           mic_q, short_q;
    assign ev_q    = r_q.ev;
    assign ien_q   = r_q.ien;
    assign en_q    = r_q.en;
    assign mic_q   = r_q.mic;
    assign short_q = r_q.sh;
endmodule

// File: rtl/pcc_chk.sv
module pcc_chk
    import pcc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              eng_start,
    input logic              eng_op,
    input logic              eng_done,
    input logic              rx_end,
    input logic              rx_crc_err,
    input logic [NTASK-1:0]  trig,
    input sq_state_e         seq_st,
    input logic [NEV-1:0]    ev_q,
    input logic [NEV-1:0]    ien_q,
    input logic [1:0]        en_q,
    input logic              mic_q,
    input logic              short_q
);
    AST_TASK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q != EN_ON && seq_st == SQ_IDLE) |=> !eng_start);  // R2

    AST_KS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (trig[0] && en_q == EN_ON && !trig[1] && !trig[2]
         && !(seq_st == SQ_KS && eng_done)) |=> (eng_start && !eng_op));  // R3

    AST_EV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q[1] && !(bus_wr && bus_addr == A_EV_BASE + 12'h004)) |=> ev_q[1]);  // R4

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == SQ_KS && eng_done && ien_q[0] && !bus_wr) |=> irq);  // R6

    AST_SHORT_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == SQ_KS && eng_done && short_q && en_q == EN_ON && !trig[2])
        |=> (seq_st == SQ_ENC || seq_st == SQ_RXW));  // R7

    AST_CRC_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == SQ_RXW && rx_end && rx_crc_err && trig[2:0] == 3'b000)
        |=> (!mic_q && ev_q[1] && !eng_start));  // R10

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig[2] |=> seq_st == SQ_IDLE);  // R11

    AST_TASK_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < 12'h010) |-> bus_rdata == '0);  // R14
endmodule

bind pkt_cipher_ctl pcc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .irq(irq), .eng_start(eng_start), .eng_op(eng_op),
    .eng_done(eng_done), .rx_end(rx_end), .rx_crc_err(rx_crc_err),
    .trig(trig), .seq_st(seq_st), .ev_q(ev_q), .ien_q(ien_q), .en_q(en_q),
    .mic_q(mic_q), .short_q(short_q));

// File: tb/pkt_cipher_ctl_tb_top.sv
module pkt_cipher_ctl_tb_top;
    localparam int NCH = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq, eng_start, eng_op, eng_decrypt;
    logic [NCH-1:0] chan_in = '0, chan_out;
    logic eng_done = 1'b0, eng_mic_ok = 1'b0, rx_end = 1'b0, rx_crc_err = 1'b0;

    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    pkt_cipher_ctl #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .chan_in(chan_in), .chan_out(chan_out), .eng_start(eng_start),
        .eng_op(eng_op), .eng_decrypt(eng_decrypt), .eng_done(eng_done),
        .eng_mic_ok(eng_mic_ok), .rx_end(rx_end), .rx_crc_err(rx_crc_err));

    // {address, write data, expected read-back, requirement number}
    localparam int NV = 17;
    localparam logic [79:0] VTAB [NV] = '{
        {12'h304, 32'h0000_0005, 32'h0000_0005, 4'd5},   // R5 set
        {12'h308, 32'h0000_0001, 32'h0000_0004, 4'd5},   // R5 clear, read at clear address
        {12'h304, 32'hFFFF_FFF8, 32'h0000_0004, 4'd5},   // R5 only 3 bits
        {12'h504, 32'hFFFF_FFFF, 32'h0103_0001, 4'd1},   // R1 mode fields
        {12'h504, 32'h0000_0000, 32'h0000_0000, 4'd1},
        {12'h200, 32'h0000_FFFF, 32'h0000_0001, 4'd7},   // R7 shortcut bit
        {12'h200, 32'h0000_0000, 32'h0000_0000, 4'd7},
        {12'h500, 32'h0000_000F, 32'h0000_0003, 4'd2},   // R2 enable width
        {12'h500, 32'h0000_0000, 32'h0000_0000, 4'd2},
        {12'h080, 32'hFFFF_FFFF, 32'h8000_00FF, 4'd12},  // R12 subscribe layout
        {12'h080, 32'h0000_0000, 32'h0000_0000, 4'd12},
        {12'h184, 32'h7FFF_FF05, 32'h0000_0005, 4'd13},  // R13 publish layout
        {12'h520, 32'h0000_01AB, 32'h0000_00AB, 4'd1},   // R1 header mask
        {12'h000, 32'h0000_0001, 32'h0000_0000, 4'd14},  // R14 task reads 0
        {12'h108, 32'h0000_0001, 32'h0000_0001, 4'd4},   // R4 set by write
        {12'h108, 32'h0000_0000, 32'h0000_0000, 4'd4},   // R4 clear by write
        {12'h50C, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd1}    // R1 pointer storage
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic done_pulse(input logic ok);
        @(negedge clk);
        eng_done = 1'b1; eng_mic_ok = ok;
        @(negedge clk);
        eng_done = 1'b0; eng_mic_ok = 1'b0;
    endtask

    task automatic rx_pulse(input logic crc);
        @(negedge clk);
        rx_end = 1'b1; rx_crc_err = crc;
        @(negedge clk);
        rx_end = 1'b0; rx_crc_err = 1'b0;
    endtask

    task automatic chan_pulse(input int line);
        @(negedge clk);
        chan_in = '0; chan_in[line] = 1'b1;
        @(negedge clk);
        chan_in = '0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h504, v); chk("R1 mode reset", v, 32'h1);
        rd(12'h520, v); chk("R1 header mask reset", v, 32'hE3);
        rd(12'h100, v); chk("R1 event reset", v, 32'h0);
        rd(12'h304, v); chk("R1 enable mask reset", v, 32'h0);
        rd(12'h400, v); chk("R1 status reset", v, 32'h0);
        chk("R1 irq reset", {31'd0, irq}, 32'h0);
        chk("R1 start reset", {31'd0, eng_start}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [11:0] a; logic [31:0] d, e; logic [3:0] q;
            {a, d, e, q} = VTAB[i];
            wr(a, d);
            rd(a, v);
            n_run++;
            if (v !== e) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: got 0x%08h expected 0x%08h", q, i, v, e);
            end
        end
        wr(12'h308, 32'h7);

        // R6 level interrupt follows flag and enable
        wr(12'h108, 32'h1);
        chk("R6 flag without enable", {31'd0, irq}, 32'h0);
        wr(12'h304, 32'h4);
        chk("R6 enable raises irq", {31'd0, irq}, 32'h1);
        wr(12'h308, 32'h4);
        chk("R6 enable clear drops irq", {31'd0, irq}, 32'h0);
        wr(12'h304, 32'h4);
        wr(12'h108, 32'h0);
        chk("R6 flag clear drops irq", {31'd0, irq}, 32'h0);
        wr(12'h308, 32'h7);

        // R2 tasks ignored while disabled
        wr(12'h000, 32'h1);
        chk("R2 no start when disabled", {31'd0, eng_start}, 32'h0);
        done_pulse(1'b1);
        rd(12'h100, v); chk("R2 no event when disabled", v, 32'h0);

        // R3 keystream job, R13 publish on line 3
        wr(12'h500, 32'h2);
        wr(12'h504, 32'h0);
        wr(12'h304, 32'h3);
        wr(12'h180, 32'h8000_0003);
        wr(12'h000, 32'h1);
        chk("R3 start pulse", {30'd0, eng_start, eng_op}, 32'h2);
        @(negedge clk);
        chk("R3 start one cycle", {31'd0, eng_start}, 32'h0);
        done_pulse(1'b0);
        rd(12'h100, v); chk("R3 keystream event", v, 32'h1);
        chk("R6 irq on keystream event", {31'd0, irq}, 32'h1);
        chk("R13 publish pulse", {16'd0, chan_out}, 32'h0008);
        @(negedge clk);
        chk("R13 publish one cycle", {16'd0, chan_out}, 32'h0);
        wr(12'h100, 32'h0);
        wr(12'h180, 32'h0);

        // R14 rate override task does nothing
        wr(12'h00C, 32'h1);
        chk("R14 rate task no start", {31'd0, eng_start}, 32'h0);
        rd(12'h504, v); chk("R14 rate task mode untouched", v, 32'h0);

        // R8 encrypt job
        wr(12'h004, 32'h1);
        chk("R8 crypt start", {30'd0, eng_start, eng_op}, 32'h3);
        done_pulse(1'b1);
        rd(12'h104, v); chk("R8 crypt event", v, 32'h1);
        rd(12'h400, v); chk("R8 status untouched", v, 32'h0);
        wr(12'h104, 32'h0);

        // R7 shortcut keystream into crypt
        wr(12'h200, 32'h1);
        wr(12'h000, 32'h1);
        done_pulse(1'b0);
        rd(12'h100, v); chk("R7 keystream event", v, 32'h1);
        chk("R7 chained start", {30'd0, eng_start, eng_op}, 32'h3);
        done_pulse(1'b0);
        rd(12'h104, v); chk("R7 chained crypt event", v, 32'h1);
        wr(12'h200, 32'h0);
        wr(12'h100, 32'h0);
        wr(12'h104, 32'h0);

        // R9 decrypt waits for end of packet
        wr(12'h504, 32'h1);
        wr(12'h004, 32'h1);
        chk("R9 no start before rx_end", {31'd0, eng_start}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R9 still waiting", {31'd0, eng_start}, 32'h0);
        rx_pulse(1'b0);
        chk("R9 start after rx_end", {30'd0, eng_start, eng_op}, 32'h3);
        done_pulse(1'b0);
        rd(12'h400, v); chk("R9 status fail", v, 32'h0);
        rd(12'h104, v); chk("R9 crypt event", v, 32'h1);
        wr(12'h104, 32'h0);
        wr(12'h004, 32'h1);
        rx_pulse(1'b0);
        done_pulse(1'b1);
        rd(12'h400, v); chk("R9 status pass", v, 32'h1);
        wr(12'h104, 32'h0);

        // R10 CRC error skips the check
        wr(12'h004, 32'h1);
        rx_pulse(1'b1);
        chk("R10 no engine job", {31'd0, eng_start}, 32'h0);
        rd(12'h400, v); chk("R10 status forced 0", v, 32'h0);
        rd(12'h104, v); chk("R10 crypt event", v, 32'h1);
        wr(12'h104, 32'h0);

        // R11 stop cancels a pending decrypt
        wr(12'h004, 32'h1);
        wr(12'h008, 32'h1);
        rx_pulse(1'b0);
        chk("R11 no start after stop", {31'd0, eng_start}, 32'h0);
        done_pulse(1'b1);
        rd(12'h104, v); chk("R11 no event after stop", v, 32'h0);

        // R12 subscriptions
        wr(12'h504, 32'h0);
        wr(12'h080, 32'h8000_0002);
        wr(12'h084, 32'h0000_0004);
        chan_pulse(5);
        chk("R12 other line ignored", {31'd0, eng_start}, 32'h0);
        chan_pulse(4);
        chk("R12 disabled subscription ignored", {31'd0, eng_start}, 32'h0);
        chan_pulse(2);
        chk("R12 subscribed task fires", {30'd0, eng_start, eng_op}, 32'h2);
        done_pulse(1'b0);
        rd(12'h100, v); chk("R12 subscribed job completes", v, 32'h1);

        finish_run();
    end
endmodule